// File: doc/BRIEF.md
# Servo Position Range Scaler

This block converts a small unsigned position code into the pulse-width command word that a servo drive expects. The position range maps linearly onto a command window. With the default settings, codes 0 to 63 are spread across commands 0x0CCC to 0x1999. The block uses no real-number hardware. By default it multiplies the position offset by a fixed-point step constant with many fraction bits, rounds to nearest, and adds the lower command limit. A parameter can instead select a lookup table that is filled at elaboration time with exactly rounded values.

The command is registered, so a new position appears at the output one clock after it is sampled. Positions outside the configured input window saturate at the matching end of the command window. A downstream pulse generator can therefore consume the command word directly.

Top module: `servo_range_scaler`

## Requirements
- R1: While the active-low reset rstN is low, and on the first cycle after its release, cmdOut equals MIN_OUT (0x0CCC by default). Reset acts asynchronously.
- R2: A position equal to MIN_IN (0 by default) yields exactly MIN_OUT (0x0CCC).
- R3: A position equal to MAX_IN (63 by default) yields exactly MAX_OUT (0x1999).
- R4: For a position p inside the window, cmdOut = MIN_OUT + round-to-nearest((p - MIN_IN) * (MAX_OUT - MIN_OUT) / (MAX_IN - MIN_IN)). With the defaults, p=1 gives 0x0D00, p=16 gives 0x100C, p=31 gives 0x1318, p=32 gives 0x134D and p=62 gives 0x1965.
- R5: cmdOut shows the result for the position sampled at the previous rising clock edge. The output keeps its old value until that edge, and it stays constant while the position is held.
- R6: A position below MIN_IN yields MIN_OUT, and a position above MAX_IN yields MAX_OUT.
- R7: cmdOut never leaves the range MIN_OUT to MAX_OUT.
- R8: With USE_TABLE=1, the table variant gives the same command as the fixed-point variant for every position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| posIn | input | IN_W | Unsigned position code |
| cmdOut | output | OUT_W | Registered pulse-width command |

## Verification
The block holds only one state register, the command word. A wrong value in it shows at cmdOut one clock after the position is sampled. Under a held position it persists visibly, so the full sweep of every code exposes any bad step constant, rounding offset or table entry within a cycle. Saturation faults can only be seen when the input window is narrower than the code space, so a narrowed instance observes codes on both sides of the window.

// File: rtl/servo_scale_pkg.sv
package servo_scale_pkg;

  // Strobes from the window decoder to the datapath
  typedef struct packed {
    logic clampLo;
    logic clampHi;
  } scale_ctrl_t;

  // Exactly rounded offset for table entry idx
  function automatic longint unsigned roundedOffset(
    input longint unsigned idx,
    input longint unsigned rangeIn,
    input longint unsigned rangeOut
  );
    longint unsigned num;
    num = idx * rangeOut * 2 + rangeIn;
    return num / (rangeIn * 2);
  endfunction

  // Fixed-point step with fracW fraction bits, truncated
  function automatic longint unsigned stepConst(
    input longint unsigned rangeIn,
    input longint unsigned rangeOut,
    input int              fracW
  );
    return (rangeOut << fracW) / rangeIn;
  endfunction

endpackage

// File: rtl/servo_scale_ctrl.sv
module servo_scale_ctrl
  import servo_scale_pkg::*;
#(
  parameter int IN_W   = 6,
  parameter int MIN_IN = 0,
  parameter int MAX_IN = 63
) (
  input  logic [IN_W-1:0] posIn,
  output scale_ctrl_t     ctrl
);

  int posVal;

  always_comb begin
    posVal       = int'(posIn);
    ctrl.clampLo = (posVal < MIN_IN);
    ctrl.clampHi = (posVal > MAX_IN);
  end

endmodule

// File: rtl/servo_scale_datapath.sv
module servo_scale_datapath
  import servo_scale_pkg::*;
#(
  parameter int IN_W      = 6,
  parameter int OUT_W     = 16,
  parameter int MIN_IN    = 0,
  parameter int MAX_IN    = 63,
  parameter int MIN_OUT   = 'h0CCC,
  parameter int MAX_OUT   = 'h1999,
  parameter int FRAC_W    = 19,
  parameter bit USE_TABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IN_W-1:0]   posIn,
  input  scale_ctrl_t       ctrl,
  output logic [OUT_W-1:0]  cmdOut
);

  localparam longint unsigned RANGE_IN  = longint'(MAX_IN - MIN_IN);
  localparam longint unsigned RANGE_OUT = longint'(MAX_OUT - MIN_OUT);
  localparam int              ENTRIES   = 2 ** IN_W;

  logic [IN_W-1:0]  offset;
  logic [OUT_W-1:0] nextCmd;
  logic [OUT_W-1:0] cmdQ;

  // Offset into the window, saturated by the decoder strobes
  always_comb begin
    if (ctrl.clampLo)      offset = '0;
    else if (ctrl.clampHi) offset = IN_W'(RANGE_IN);
    else                   offset = posIn - IN_W'(MIN_IN);
  end

  generate
    if (USE_TABLE) begin : g_table
      logic [OUT_W-1:0] lut [ENTRIES];
      for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        if (k <= int'(RANGE_IN)) begin : g_in
          assign lut[k] = OUT_W'(longint'(MIN_OUT) +
                          roundedOffset(longint'(k), RANGE_IN, RANGE_OUT));
        end else begin : g_out
          assign lut[k] = OUT_W'(MAX_OUT);
        end
      end
      assign nextCmd = lut[offset];
    end else begin : g_fixed
      localparam longint unsigned STEP_Q = stepConst(RANGE_IN, RANGE_OUT, FRAC_W);
      localparam longint unsigned HALF   = longint'(1) << (FRAC_W - 1);
      localparam int STEP_W = $clog2(STEP_Q + 1);
      localparam int PROD_W = IN_W + STEP_W + 1;
      localparam int INT_W  = PROD_W - FRAC_W;

      logic [PROD_W-1:0] prod;
      logic [INT_W-1:0]  whole;

      always_comb begin
        prod  = PROD_W'(offset) * PROD_W'(STEP_Q) + PROD_W'(HALF);
        whole = prod[PROD_W-1:FRAC_W];
      end
      assign nextCmd = OUT_W'(whole) + OUT_W'(MIN_OUT);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdQ <= OUT_W'(MIN_OUT);
    else       cmdQ <= nextCmd;
  end

  assign cmdOut = cmdQ;

endmodule

// File: rtl/servo_range_scaler.sv
module servo_range_scaler
  import servo_scale_pkg::*;
#(
  parameter int IN_W      = 6,
  parameter int OUT_W     = 16,
  parameter int MIN_IN    = 0,
  parameter int MAX_IN    = 63,
  parameter int MIN_OUT   = 'h0CCC,
  parameter int MAX_OUT   = 'h1999,
  parameter int FRAC_W    = 19,
  parameter bit USE_TABLE = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  posIn,
  output logic [OUT_W-1:0] cmdOut
);

  scale_ctrl_t ctrl;

  servo_scale_ctrl #(
    .IN_W   (IN_W),
    .MIN_IN (MIN_IN),
    .MAX_IN (MAX_IN)
  ) i_ctrl (
    .posIn (posIn),
    .ctrl  (ctrl)
  );

  servo_scale_datapath #(
    .IN_W      (IN_W),
    .OUT_W     (OUT_W),
    .MIN_IN    (MIN_IN),
    .MAX_IN    (MAX_IN),
    .MIN_OUT   (MIN_OUT),
    .MAX_OUT   (MAX_OUT),
    .FRAC_W    (FRAC_W),
    .USE_TABLE (USE_TABLE)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .posIn  (posIn),
    .ctrl   (ctrl),
    .cmdOut (cmdOut)
  );

endmodule

// File: rtl/servo_range_scaler_chk.sv
module servo_range_scaler_chk #(
  parameter int IN_W    = 6,
  parameter int OUT_W   = 16,
  parameter int MIN_IN  = 0,
  parameter int MAX_IN  = 63,
  parameter int MIN_OUT = 'h0CCC,
  parameter int MAX_OUT = 'h1999
) (
  input logic             clk,
  input logic             rstN,
  input logic [IN_W-1:0]  posIn,
  input logic [OUT_W-1:0] cmdOut
);

  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  rst_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> cmdOut == OUT_W'(MIN_OUT));

  // R2
  min_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && int'($past(posIn)) == MIN_IN |-> cmdOut == OUT_W'(MIN_OUT));

  // R3
  max_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && int'($past(posIn)) == MAX_IN |-> cmdOut == OUT_W'(MAX_OUT));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && $stable(posIn) |=> $stable(cmdOut));

  // R6
  clamp_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && int'($past(posIn)) < MIN_IN |-> cmdOut == OUT_W'(MIN_OUT));

  // R6
  clamp_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && int'($past(posIn)) > MAX_IN |-> cmdOut == OUT_W'(MAX_OUT));

  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut >= OUT_W'(MIN_OUT) && cmdOut <= OUT_W'(MAX_OUT));

endmodule

bind servo_range_scaler servo_range_scaler_chk #(
  .IN_W    (IN_W),
  .OUT_W   (OUT_W),
  .MIN_IN  (MIN_IN),
  .MAX_IN  (MAX_IN),
  .MIN_OUT (MIN_OUT),
  .MAX_OUT (MAX_OUT)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .posIn  (posIn),
  .cmdOut (cmdOut)
);

// File: tb/test_servo_range_scaler.sv
module test_servo_range_scaler;

  localparam int MIN_OUT = 'h0CCC;
  localparam int MAX_OUT = 'h1999;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  posIn = 6'd63;
  logic [15:0] cmdMain, cmdLut, cmdClamp;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  servo_range_scaler i_servo_range_scaler (
    .clk(clk), .rstN(rstN), .posIn(posIn), .cmdOut(cmdMain));

  servo_range_scaler #(.USE_TABLE(1'b1)) i_servo_range_scaler_lut (
    .clk(clk), .rstN(rstN), .posIn(posIn), .cmdOut(cmdLut));

  servo_range_scaler #(.MIN_IN(8), .MAX_IN(55)) i_servo_range_scaler_clamp (
    .clk(clk), .rstN(rstN), .posIn(posIn), .cmdOut(cmdClamp));

  // position, expected command for the default window
  localparam logic [21:0] VEC [8] = '{
    {6'd0,  16'h0CCC}, {6'd63, 16'h1999}, {6'd1,  16'h0D00},
    {6'd16, 16'h100C}, {6'd31, 16'h1318}, {6'd32, 16'h134D},
    {6'd62, 16'h1965}, {6'd0,  16'h0CCC}
  };

  function automatic int refCmd(int p, int mnI, int mxI);
    int q;
    q = (p < mnI) ? mnI : (p > mxI) ? mxI : p;
    return MIN_OUT + ((q - mnI) * (MAX_OUT - MIN_OUT) * 2 + (mxI - mnI))
                     / ((mxI - mnI) * 2);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(cmdMain), MIN_OUT);
    check("R1 in reset lut", int'(cmdLut), MIN_OUT);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 first cycle after release", int'(cmdMain), MAX_OUT);

    // Vector table: R2 R3 R4
    foreach (VEC[i]) begin
      posIn = VEC[i][21:16];
      @(negedge clk);
      check("R4 vector", int'(cmdMain), int'(VEC[i][15:0]));
    end

    // R5 latency and hold
    posIn = 6'd63;
    @(negedge clk);
    posIn = 6'd0;
    #1;
    check("R5 old value before edge", int'(cmdMain), MAX_OUT);
    @(negedge clk);
    check("R5 new value after edge", int'(cmdMain), MIN_OUT);
    @(negedge clk);
    check("R5 held", int'(cmdMain), MIN_OUT);

    // Full sweep: R4 R7 R8 R6
    for (int p = 0; p < 64; p++) begin
      posIn = 6'(p);
      @(negedge clk);
      check("R4 sweep", int'(cmdMain), refCmd(p, 0, 63));
      check("R8 table sweep", int'(cmdLut), refCmd(p, 0, 63));
      check("R6 clamp sweep", int'(cmdClamp), refCmd(p, 8, 55));
      check("R7 range", int'(cmdMain >= 16'h0CCC && cmdMain <= 16'h1999), 1);
    end

    // R6 directed edges of the narrowed window
    posIn = 6'd7;  @(negedge clk);
    check("R6 below window", int'(cmdClamp), MIN_OUT);
    posIn = 6'd8;  @(negedge clk);
    check("R2 window low end", int'(cmdClamp), MIN_OUT);
    posIn = 6'd55; @(negedge clk);
    check("R3 window high end", int'(cmdClamp), MAX_OUT);
    posIn = 6'd56; @(negedge clk);
    check("R6 above window", int'(cmdClamp), MAX_OUT);
    posIn = 6'd20; @(negedge clk);
    check("R4 narrowed interior", int'(cmdClamp), 'h1011);

    // R1 asynchronous reset mid-run
    posIn = 6'd63; @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 async reset", int'(cmdMain), MIN_OUT);
    check("R1 async reset clamp", int'(cmdClamp), MIN_OUT);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 after re-release", int'(cmdMain), MAX_OUT);

    finishRun();
  end

endmodule